// File: doc/BRIEF.md
# Pre/Post Trigger Capture Controller

This block steers a logic analyzer's sample memory. Once armed, it thins the incoming sample stream by a programmable clock divider and writes each kept sample into a circular buffer. Before the trigger the write pointer keeps wrapping, so the buffer always holds the most recent history. When the trigger is seen, the block writes a fixed number of further samples and then stops. It then hands out buffer addresses for readback, newest sample first.

Counts arrive in units of four samples and are encoded as the count minus one. The read count sets how many samples are read back in total. The delay count sets how many of them follow the trigger, so the pre-trigger history is the difference between the two. Each input sample carries four 8-bit channel groups, and any group can be switched off. Only the bytes of enabled groups are stored, packed toward the low end. The buffer is modelled as `MEM_BYTES` bytes, so the number of sample slots grows as fewer groups are enabled. The memory itself sits outside the block: the block drives a write port and supplies read addresses.

Top module: `trig_capture_ctrl`

## Requirements
- R1: `arm` is accepted only while the block is idle and `done` is low. On acceptance the block latches `cfg_read_cnt`, `cfg_delay_cnt`, `cfg_grp_off`, `cfg_div` and `trig_en`. Changes to these inputs, and further `arm` pulses, have no effect until the capture and its readback have ended.
- R2: While capturing, the block keeps one sample every `cfg_div`+1 clock cycles (24-bit divider field). Consecutive writes are therefore exactly `cfg_div`+1 cycles apart.
- R3: Group g is `smp_in[8g+7:8g]`, and `cfg_grp_off` bit g set to 1 disables group g. Enabled group bytes are packed into `mem_data` starting at bits 7:0, lowest-numbered group first, and the unused upper bytes are zero. If all four bits are set, the block behaves as if only group 0 were enabled.
- R4: With n enabled groups, the buffer holds `MEM_BYTES`/n slots (integer division). The first write after `arm` goes to slot 0, and each write moves to the next slot, wrapping from the last slot back to 0.
- R5: With `trig_en`=1, the block writes continuously until a kept sample coincides with `trig_in`=1. That sample is the first post-trigger sample, and every sample kept before it is pre-trigger history.
- R6: Counting from the trigger sample, exactly 4×(delay+1) samples are written. `done` rises in the cycle after the last of these writes, and no further write occurs while `done` is high.
- R7: With `trig_en`=0, the first kept sample after `arm` acts as the trigger sample, so the whole capture is post-trigger.
- R8: While `done` is high, `rd_addr` first points at the most recently written slot. Each `rd_next` pulse moves it one slot back, wrapping from 0 to the last slot, for 4×(read+1) positions in total. `rd_last` is high on the final position. `rd_next` taken on that position clears `done` and returns the block to idle.
- R9: After reset, `done`, `mem_we` and `rd_last` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arm | input | 1 | Start a capture (accepted when idle) |
| trig_en | input | 1 | 1: wait for `trig_in`; 0: trigger on the first kept sample |
| cfg_read_cnt | input | 16 | Total samples to read back, in fours, minus one |
| cfg_delay_cnt | input | 16 | Post-trigger samples, in fours, minus one |
| cfg_grp_off | input | 4 | Per-group disable bits |
| cfg_div | input | 24 | Sample divider: keep one sample every cfg_div+1 clocks |
| smp_in | input | 32 | Input sample, four 8-bit groups |
| trig_in | input | 1 | Trigger condition for the current sample |
| rd_next | input | 1 | Advance the readback pointer |
| mem_we | output | 1 | Buffer write enable |
| mem_addr | output | clog2(MEM_BYTES) | Buffer write slot |
| mem_data | output | 32 | Packed sample to write |
| done | output | 1 | Capture finished, readback in progress |
| rd_addr | output | clog2(MEM_BYTES) | Slot to read now |
| rd_last | output | 1 | Current readback position is the final one |

## Verification
Two events can fall in the same cycle: the trigger can land on the write that wraps the buffer from its last slot to slot 0, and the final post-trigger write can coincide with the start of readback. The first case is forced by holding off the trigger until 31 samples have been kept with two groups enabled, which gives a 32-slot buffer, so the trigger sample occupies slot 31. The bench then confirms three things: the post-trigger samples continue at slot 0, the write count stays exact, and readback walks backward through slot 0 into slot 31 with the stored data in strict newest-first order. The second case is judged by checking that `done` appears right after the last write, that no write occurs afterwards, and that the first read address equals the slot of that last write.

// File: rtl/cap_pkg.sv
package cap_pkg;
    localparam int GROUPS = 4;
    localparam int GRP_W  = 8;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_PRE  = 2'd1,
        PH_POST = 2'd2,
        PH_READ = 2'd3
    } phase_e;
endpackage

// File: rtl/cap_divider.sv
module cap_divider #(
    parameter int DIV_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = run && (cnt_q == div);
        cnt_d = cnt_q;
        if (!run || tick) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R2: a nonzero divider never yields back-to-back kept samples
    a_r2_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && div != '0) |=> !tick);
endmodule

// File: rtl/cap_packer.sv
module cap_packer
    import cap_pkg::*;
#(
    parameter int MEM_BYTES = 4096,
    parameter int AW        = 12
) (
    input  logic [GROUPS-1:0]       grp_off,
    input  logic [GROUPS*GRP_W-1:0] smp,
    output logic [GROUPS*GRP_W-1:0] packed_data,
    output logic [AW:0]             depth
);
    localparam int NW = $clog2(GROUPS + 1);

    logic [AW:0]       depth_tab [0:GROUPS];
    logic [GROUPS-1:0] keep;
    logic [NW-1:0]     n_sel;

    for (genvar g = 0; g <= GROUPS; g++) begin : g_depth
        assign depth_tab[g] = (AW+1)'(MEM_BYTES / ((g == 0) ? 1 : g));
    end

    assign keep = (grp_off == '1) ? GROUPS'(1) : ~grp_off;

    always_comb begin
        int pos;
        pos         = 0;
        packed_data = '0;
        for (int g = 0; g < GROUPS; g++) begin
            if (keep[g]) begin
                packed_data[pos*GRP_W +: GRP_W] = smp[g*GRP_W +: GRP_W];
                pos = pos + 1;
            end
        end
        n_sel = NW'(pos);
    end

    assign depth = depth_tab[n_sel];
endmodule

// File: rtl/cap_readback.sv
module cap_readback #(
    parameter int AW = 12,
    parameter int CW = 18
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] start_ptr,
    input  logic [AW:0]   depth,
    input  logic [CW-1:0] limit,
    input  logic          step,
    output logic          active,
    output logic [AW-1:0] addr,
    output logic          last
);
    typedef struct packed {
        logic          active;
        logic [AW-1:0] ptr;
        logic [CW-1:0] cnt;
    } rb_t;

    rb_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (start) begin
            r_d.active = 1'b1;
            r_d.ptr    = start_ptr;
            r_d.cnt    = '0;
        end else if (r_q.active && step) begin
            if (r_q.cnt == limit) begin
                r_d.active = 1'b0;
            end else begin
                r_d.ptr = (r_q.ptr == '0) ? AW'(depth - 1'b1) : r_q.ptr - 1'b1;
                r_d.cnt = r_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign active = r_q.active;
    assign addr   = r_q.ptr;
    assign last   = r_q.active && (r_q.cnt == limit);

    // R8: stepping past the final position ends readback
    a_r8_last_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (last && step && !start) |=> !active);
    // R8: readback address stays inside the ring
    a_r8_addr_in_ring: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> ({1'b0, addr} < depth));
endmodule

// File: rtl/trig_capture_ctrl.sv
module trig_capture_ctrl
    import cap_pkg::*;
#(
    parameter int MEM_BYTES = 4096,
    parameter int CNT_W     = 16,
    parameter int DIV_W     = 24,
    localparam int AW       = $clog2(MEM_BYTES),
    localparam int SW       = GROUPS * GRP_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm,
    input  logic             trig_en,
    input  logic [CNT_W-1:0] cfg_read_cnt,
    input  logic [CNT_W-1:0] cfg_delay_cnt,
    input  logic [GROUPS-1:0] cfg_grp_off,
    input  logic [DIV_W-1:0] cfg_div,
    input  logic [SW-1:0]    smp_in,
    input  logic             trig_in,
    input  logic             rd_next,
    output logic             mem_we,
    output logic [AW-1:0]    mem_addr,
    output logic [SW-1:0]    mem_data,
    output logic             done,
    output logic [AW-1:0]    rd_addr,
    output logic             rd_last
);
    localparam int CW = CNT_W + 2;

    typedef struct packed {
        phase_e            phase;
        logic [AW-1:0]     wr_ptr;
        logic [CW-1:0]     post_cnt;
        logic [CNT_W-1:0]  read_cnt;
        logic [CNT_W-1:0]  delay_cnt;
        logic [GROUPS-1:0] off;
        logic [DIV_W-1:0]  div;
        logic              trig_en;
    } ctl_t;

    ctl_t c_d, c_q;

    logic          tick;
    logic          run;
    logic [AW:0]   depth;
    logic [SW-1:0] packed_smp;
    logic          rb_start;
    logic          rb_active;
    logic          rb_last;
    logic [AW-1:0] rb_addr;
    logic [AW-1:0] wr_nxt;
    logic [CW-1:0] post_lim;
    logic [CW-1:0] read_lim;

    assign run      = (c_q.phase == PH_PRE) || (c_q.phase == PH_POST);
    assign post_lim = {c_q.delay_cnt, 2'b11};
    assign read_lim = {c_q.read_cnt, 2'b11};
    assign wr_nxt   = ({1'b0, c_q.wr_ptr} == depth - 1'b1) ? '0 : c_q.wr_ptr + 1'b1;

    cap_divider #(.DIV_W(DIV_W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .div   (c_q.div),
        .tick  (tick)
    );

    cap_packer #(.MEM_BYTES(MEM_BYTES), .AW(AW)) u_pack (
        .grp_off     (c_q.off),
        .smp         (smp_in),
        .packed_data (packed_smp),
        .depth       (depth)
    );

    cap_readback #(.AW(AW), .CW(CW)) u_rb (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (rb_start),
        .start_ptr (c_q.wr_ptr),
        .depth     (depth),
        .limit     (read_lim),
        .step      (rd_next),
        .active    (rb_active),
        .addr      (rb_addr),
        .last      (rb_last)
    );

    always_comb begin
        c_d      = c_q;
        mem_we   = 1'b0;
        rb_start = 1'b0;
        case (c_q.phase)
            PH_IDLE: begin
                if (arm) begin
                    c_d.phase     = PH_PRE;
                    c_d.wr_ptr    = '0;
                    c_d.post_cnt  = '0;
                    c_d.read_cnt  = cfg_read_cnt;
                    c_d.delay_cnt = cfg_delay_cnt;
                    c_d.off       = cfg_grp_off;
                    c_d.div       = cfg_div;
                    c_d.trig_en   = trig_en;
                end
            end
            PH_PRE: begin
                if (tick) begin
                    mem_we     = 1'b1;
                    c_d.wr_ptr = wr_nxt;
                    if (!c_q.trig_en || trig_in) begin
                        c_d.phase    = PH_POST;
                        c_d.post_cnt = CW'(1);
                    end
                end
            end
            PH_POST: begin
                if (tick) begin
                    mem_we     = 1'b1;
                    c_d.wr_ptr = wr_nxt;
                    if (c_q.post_cnt == post_lim) begin
                        c_d.phase = PH_READ;
                        rb_start  = 1'b1;
                    end else begin
                        c_d.post_cnt = c_q.post_cnt + 1'b1;
                    end
                end
            end
            PH_READ: begin
                if (rb_last && rd_next) begin
                    c_d.phase = PH_IDLE;
                end
            end
            default: c_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign mem_addr = c_q.wr_ptr;
    assign mem_data = packed_smp;
    assign done     = (c_q.phase == PH_READ);
    assign rd_addr  = rb_addr;
    assign rd_last  = rb_last;

    // R4: writes land inside the ring sized for the enabled groups
    a_r4_addr_in_ring: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> ({1'b0, mem_addr} < depth));
    // R6: nothing is written once the capture has finished
    a_r6_quiet_when_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !mem_we);
    // R6: done rises only right after a write
    a_r6_done_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(mem_we));
    // R8: readback state and done agree
    a_r8_done_tracks_rb: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> rb_active);
    // R1: latched divider and group mask hold while busy
    a_r1_cfg_held: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.phase != PH_IDLE) |=> ((c_q.phase == PH_IDLE) || ($stable(c_q.div) && $stable(c_q.off))));
endmodule

// File: tb/trig_capture_ctrl_test.sv
module trig_capture_ctrl_test;
    localparam int MB = 64;
    localparam int AW = 6;

    logic        clk = 1'b0;
    logic        rst_n, arm, trig_en, trig_in, rd_next;
    logic [15:0] cfg_read_cnt, cfg_delay_cnt;
    logic [3:0]  cfg_grp_off;
    logic [23:0] cfg_div;
    logic [31:0] smp_in;
    logic        mem_we, done, rd_last;
    logic [AW-1:0] mem_addr, rd_addr;
    logic [31:0] mem_data;

    always #5 clk = ~clk;

    trig_capture_ctrl #(.MEM_BYTES(MB)) uut (
        .clk(clk), .rst_n(rst_n), .arm(arm), .trig_en(trig_en),
        .cfg_read_cnt(cfg_read_cnt), .cfg_delay_cnt(cfg_delay_cnt),
        .cfg_grp_off(cfg_grp_off), .cfg_div(cfg_div), .smp_in(smp_in),
        .trig_in(trig_in), .rd_next(rd_next), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_data(mem_data), .done(done),
        .rd_addr(rd_addr), .rd_last(rd_last)
    );

    int tests = 0, fails = 0;
    int seq = 0, cyc = 0;
    int wcount, post_w, bad_addr, bad_data, bad_gap, last_cyc;
    bit trig_seen, cur_ten, finished = 0;
    logic [3:0] cur_off;
    int cur_depth, cur_div;
    logic [31:0] memm [0:MB-1];
    int wseq [0:511];

    function automatic logic [31:0] pat(int s);
        logic [7:0] b;
        b = s[7:0];
        return {b ^ 8'h5A, b + 8'h33, ~b, b};
    endfunction

    function automatic logic [31:0] pack(logic [3:0] off, int s);
        logic [31:0] v, r;
        logic [3:0] en;
        int p;
        v  = pat(s);
        r  = '0;
        p  = 0;
        en = (off == 4'hF) ? 4'h1 : ~off;
        for (int g = 0; g < 4; g++)
            if (en[g]) begin r[p*8 +: 8] = v[g*8 +: 8]; p++; end
        return r;
    endfunction

    function automatic int depth_of(logic [3:0] off);
        int n;
        n = $countones(~off);
        if (n == 0) n = 1;
        return MB / n;
    endfunction

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
        seq++;
        smp_in = pat(seq);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    // write monitor, sampled away from the active edge
    always @(negedge clk) begin
        cyc++;
        if (rst_n && mem_we) begin
            if (int'(mem_addr) != (wcount % cur_depth)) bad_addr++;
            if (mem_data != pack(cur_off, seq)) bad_data++;
            if (wcount > 0 && (cyc - last_cyc) != cur_div + 1) bad_gap++;
            last_cyc = cyc;
            memm[mem_addr] = mem_data;
            if (wcount < 512) wseq[wcount] = seq;
            if (!trig_seen && (!cur_ten || trig_in)) trig_seen = 1;
            if (trig_seen) post_w++;
            wcount++;
        end
    end

    task automatic run_capture(input string tag, input logic [3:0] off, input int div,
                               input bit ten, input int rd, input int dl,
                               input int pre, input bit disturb);
        int n, w0, idx;
        cur_off = off; cur_div = div; cur_ten = ten; cur_depth = depth_of(off);
        wcount = 0; post_w = 0; bad_addr = 0; bad_data = 0; bad_gap = 0; trig_seen = 0;
        cfg_grp_off = off; cfg_div = 24'(div); trig_en = ten;
        cfg_read_cnt = 16'(rd); cfg_delay_cnt = 16'(dl);
        arm = 1; step(); arm = 0;
        if (disturb) begin
            cfg_delay_cnt = 16'd9; cfg_read_cnt = 16'd9; cfg_div = 24'd5;
            cfg_grp_off = 4'hE; trig_en = ~ten;
            arm = 1; step(); arm = 0;
        end
        if (ten) begin
            for (int k = 0; k < 4000 && wcount < pre; k++) step();
            trig_in = 1;
            for (int k = 0; k < 4000 && !trig_seen; k++) step();
            trig_in = 0;
        end
        for (int k = 0; k < 4000 && !done; k++) step();
        chk(done, {tag, " R6 done after post-trigger writes"}, done, 1);
        chk(post_w == 4*(dl+1), {tag, " R6 post-trigger write count"}, post_w, 4*(dl+1));
        if (ten)
            chk(wcount == pre + 4*(dl+1), {tag, " R5 pre-trigger history count"}, wcount, pre + 4*(dl+1));
        else
            chk(wcount == 4*(dl+1), {tag, " R7 whole capture post-trigger"}, wcount, 4*(dl+1));
        chk(bad_addr == 0, {tag, " R4 write slot sequence and wrap"}, bad_addr, 0);
        chk(bad_data == 0, {tag, " R3 packed write data"}, bad_data, 0);
        chk(bad_gap == 0, {tag, " R2 spacing between writes"}, bad_gap, 0);
        w0 = wcount;
        step(); step();
        chk(wcount == w0 && done, {tag, " R6 no writes while done"}, wcount, w0);
        n = 4*(rd+1);
        for (int i = 0; i < n; i++) begin
            idx = wcount - 1 - i;
            chk(int'(rd_addr) == idx % cur_depth, {tag, " R8 readback address"}, rd_addr, idx % cur_depth);
            chk(memm[rd_addr] == pack(off, wseq[idx]), {tag, " R8 newest-first data"},
                memm[rd_addr], pack(off, wseq[idx]));
            chk(rd_last == (i == n-1), {tag, " R8 rd_last position"}, rd_last, (i == n-1));
            rd_next = 1; step(); rd_next = 0;
        end
        chk(!done, {tag, " R8 done clears after final read"}, done, 0);
    endtask

    task automatic t_reset();
        rst_n = 0;
        repeat (3) step();
        chk(!done, "R9 done low after reset", done, 0);
        chk(!mem_we, "R9 no write after reset", mem_we, 0);
        chk(!rd_last, "R9 rd_last low after reset", rd_last, 0);
        rst_n = 1;
        step();
    endtask

    task automatic t_free_run();     run_capture("free", 4'h0, 0, 0, 1, 1, 0, 0); endtask
    task automatic t_pretrig_wrap(); run_capture("wrap", 4'h0, 0, 1, 3, 1, 20, 0); endtask
    task automatic t_divider();      run_capture("div",  4'h0, 2, 0, 0, 0, 0, 0); endtask
    task automatic t_pack_two();     run_capture("two",  4'b0101, 0, 1, 7, 0, 31, 0); endtask
    task automatic t_pack_three();   run_capture("three", 4'b0010, 1, 1, 3, 2, 25, 0); endtask
    task automatic t_all_off();      run_capture("alloff", 4'hF, 0, 0, 0, 0, 0, 0); endtask
    task automatic t_cfg_locked();   run_capture("R1 locked", 4'h0, 0, 1, 1, 1, 5, 1); endtask

    initial begin
        #1_000_000;
        fails++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        rst_n = 0; arm = 0; trig_en = 0; trig_in = 0; rd_next = 0;
        cfg_read_cnt = 0; cfg_delay_cnt = 0; cfg_grp_off = 0; cfg_div = 0;
        smp_in = 0; cur_off = 0; cur_div = 0; cur_ten = 0; cur_depth = MB;
        wcount = 0; post_w = 0; bad_addr = 0; bad_data = 0; bad_gap = 0;
        last_cyc = 0; trig_seen = 0;
        t_reset();
        t_free_run();
        t_pretrig_wrap();
        t_divider();
        t_pack_two();
        t_pack_three();
        t_all_off();
        t_cfg_locked();
        summary();
    end
endmodule